// File: doc/BRIEF.md
# AUX Reply Status Classifier

After an auxiliary-channel transaction has been launched, this block waits for the receiver to signal completion and then classifies the result. A one-cycle `start` pulse loads a programmable wait length. The block samples the completion flag on every cycle until it is seen, the hot-plug-lost flag rises, or the wait length runs out. At that point it captures the receiver error flags, the reply byte count and the reply bytes, and computes one outcome: success, timeout, invalid reply or disconnect.

On success the upper nibble of the first reply byte is decoded into a reply kind. When that kind is a plain acknowledge, the bytes after the status byte are copied into an output buffer. The copy is limited by the caller's buffer size. All results are registered and announced by a single-cycle `res_valid` pulse. The results stay on the outputs until the next result is produced. Building the request and deciding whether to retry belong to the surrounding logic.

Top module: `aux_reply_classifier`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0, `outcome` is 0, `kind` is 7 (none), `data_cnt` is 0 and `data_out` is all zero.
- R2: A `start` seen while idle loads `tmo_cycles` (T). `done_in` is then sampled on up to T+1 consecutive cycles. If it is never seen, `outcome` is 1 (timeout) and `kind` is 7. `res_valid` rises T+1 cycles after the cycle in which `start` was sampled.
- R3: `hpd_lost` high on a sampling cycle ends the wait at once, even when done is low. It gives `outcome` 3 (disconnect) and `kind` 7, whatever the other inputs are.
- R4: With done seen and no disconnect, `rx_flags` bit 0 (timeout state) or bit 1 (timeout) gives `outcome` 1. These bits take precedence over the line-error bits.
- R5: Otherwise, any of `rx_flags` bits 2..5 (bad stop, no detect, invalid high, invalid low) gives `outcome` 2 (invalid reply) and `kind` 7.
- R6: `rx_flags` bit 6 (minimum-count debug flag) has no effect on any output.
- R7: A `reply_cnt` of zero with no error flags gives `outcome` 2.
- R8: Otherwise `outcome` is 0 and `kind` is decoded from bits 7:4 of reply byte 0. Code 0 gives ACK (0), 1 gives NACK (1), 2 gives DEFER (2), 4 gives I2C NACK (3) and 8 gives I2C DEFER (4). Any other code gives invalid (5). Bits 3:0 are ignored.
- R9: For an ACK, `data_cnt` = min(`reply_cnt`-1, `buf_size`, MAX_BYTES-1). Data byte i (bits 8i+7:8i) equals reply byte i+1 for i < `data_cnt`, and is zero above that.
- R10: For every result other than ACK, `data_cnt` is 0 and `data_out` is all zero.
- R11: `res_valid` is high for exactly one cycle per result. The result outputs hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin waiting for a reply (ignored while busy) |
| tmo_cycles | input | TMO_W | Wait length T; done is sampled T+1 times |
| done_in | input | 1 | Receiver transaction complete |
| hpd_lost | input | 1 | Hot-plug disconnect seen |
| rx_flags | input | 7 | Receiver flags: 0 tmo state, 1 tmo, 2 bad stop, 3 no detect, 4 invalid high, 5 invalid low, 6 debug |
| reply_cnt | input | CNT_W | Reply byte count including the status byte |
| reply_bytes | input | MAX_BYTES*8 | Reply bytes, byte 0 in bits 7:0 |
| buf_size | input | CNT_W | Caller buffer size in bytes |
| busy | output | 1 | Waiting for completion |
| res_valid | output | 1 | One-cycle result strobe |
| outcome | output | 2 | 0 success, 1 timeout, 2 invalid, 3 disconnect |
| kind | output | 3 | 0 ACK, 1 NACK, 2 DEFER, 3 I2C NACK, 4 I2C DEFER, 5 invalid, 7 none |
| data_cnt | output | CNT_W | Bytes copied to `data_out` |
| data_out | output | (MAX_BYTES-1)*8 | Copied payload, zero-filled |

## Verification
A wrong wait counter shows as a `res_valid` that arrives one or more cycles early or late relative to T+1. The bench measures that latency on every run. A wrong priority among disconnect, timeout and line-error flags gives the wrong `outcome` on the very strobe that follows the capture. A wrong clamp or byte offset in the copier gives a wrong `data_cnt` or a shifted `data_out` on that same strobe. Because each result is registered, every fault is visible exactly one cycle after the capturing edge.

// File: rtl/aux_cls_pkg.sv
// Package: shared encodings for the AUX reply classifier.
// Assumes: outcome and kind codes are fixed and visible at the top ports.
package aux_cls_pkg;

    typedef enum logic [1:0] {
        OUT_OK     = 2'd0,
        OUT_TMO    = 2'd1,
        OUT_BAD    = 2'd2,
        OUT_UNPLUG = 2'd3
    } outcome_e;

    typedef enum logic [2:0] {
        K_ACK       = 3'd0,
        K_NACK      = 3'd1,
        K_DEFER     = 3'd2,
        K_I2C_NACK  = 3'd3,
        K_I2C_DEFER = 3'd4,
        K_BAD       = 3'd5,
        K_NONE      = 3'd7
    } kind_e;

    localparam int FLAG_W      = 7;
    localparam int F_TMO_STATE = 0;
    localparam int F_TMO       = 1;
    localparam int F_BAD_STOP  = 2;
    localparam int F_NO_DET    = 3;
    localparam int F_INV_HI    = 4;
    localparam int F_INV_LO    = 5;
    localparam int F_DEBUG     = 6;

    // Map the status nibble of reply byte 0 to a reply kind.
    function automatic kind_e decode_kind(input logic [3:0] code);
        case (code)
            4'd0:    return K_ACK;
            4'd1:    return K_NACK;
            4'd2:    return K_DEFER;
            4'd4:    return K_I2C_NACK;
            4'd8:    return K_I2C_DEFER;
            default: return K_BAD;
        endcase
    endfunction

endpackage

// File: rtl/aux_done_waiter.sv
// Module: waits for receiver completion with a bounded cycle count.
// Does: after start, samples done_in and hpd_lost every cycle; fires when
// either is seen or when the loaded count has reached zero.
// Assumes: start is ignored while a wait is in progress.
module aux_done_waiter #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMO_W-1:0] tmo_cycles,
    input  logic             done_in,
    input  logic             hpd_lost,
    output logic             busy,
    output logic             fire,
    output logic             expired
);

    logic             waiting;
    logic [TMO_W-1:0] left;

    // Fire when completion, disconnect or an exhausted count is seen.
    always_comb begin
        fire    = waiting && (hpd_lost || done_in || (left == '0));
        expired = waiting && !hpd_lost && !done_in;
    end

    // Load the count on start, count down while waiting, stop on fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
            left    <= '0;
        end else if (!waiting) begin
            if (start) begin
                waiting <= 1'b1;
                left    <= tmo_cycles;
            end
        end else if (fire) begin
            waiting <= 1'b0;
        end else begin
            left <= left - 1'b1;
        end
    end

    assign busy = waiting;

    // R2
    wait_ends_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && left == '0) |=> !waiting);

    // R2
    start_begins_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && start) |=> (waiting && left == $past(tmo_cycles)));

endmodule

// File: rtl/aux_status_decoder.sv
// Module: combinational classification of a captured receiver status.
// Does: applies disconnect > timeout > line error > empty reply priority,
// then decodes the reply kind from the status nibble.
// Assumes: expired is high only when the wait ended without done.
module aux_status_decoder
    import aux_cls_pkg::*;
(
    input  logic              hpd_lost,
    input  logic              expired,
    input  logic [FLAG_W-1:0] rx_flags,
    input  logic              cnt_zero,
    input  logic [7:0]        status_byte,
    output outcome_e          outcome,
    output kind_e             kind,
    output logic              is_ack
);

    logic tmo_hit;
    logic line_err;
    logic unused_bits;

    // Group the receiver flags; the debug flag takes part in nothing.
    always_comb begin
        tmo_hit  = rx_flags[F_TMO_STATE] | rx_flags[F_TMO];
        line_err = rx_flags[F_BAD_STOP] | rx_flags[F_NO_DET]
                 | rx_flags[F_INV_HI]   | rx_flags[F_INV_LO];
    end

    assign unused_bits = ^{rx_flags[F_DEBUG], status_byte[3:0]};

    // Priority selection of the outcome and reply kind.
    always_comb begin
        outcome = OUT_OK;
        kind    = K_NONE;
        if (hpd_lost) begin
            outcome = OUT_UNPLUG;
        end else if (expired || tmo_hit) begin
            outcome = OUT_TMO;
        end else if (line_err || cnt_zero) begin
            outcome = OUT_BAD;
        end else begin
            outcome = OUT_OK;
            kind    = decode_kind(status_byte[7:4]);
        end
        is_ack = (outcome == OUT_OK) && (kind == K_ACK);
    end

endmodule

// File: rtl/aux_payload_copier.sv
// Module: clamps and copies reply payload bytes into the caller buffer.
// Does: count = min(reply_cnt-1, buf_size, DATA_BYTES) when enabled, else 0;
// bytes above the count are driven to zero.
// Assumes: payload byte 0 is the first byte after the status byte.
module aux_payload_copier #(
    parameter int DATA_BYTES = 16,
    parameter int CNT_W      = 5
) (
    input  logic                    enable,
    input  logic [CNT_W-1:0]        reply_cnt,
    input  logic [CNT_W-1:0]        buf_size,
    input  logic [DATA_BYTES*8-1:0] payload,
    output logic [CNT_W-1:0]        copy_cnt,
    output logic [DATA_BYTES*8-1:0] data_out
);

    localparam logic [CNT_W-1:0] DATA_CAP = CNT_W'(DATA_BYTES);

    logic [CNT_W-1:0] avail;
    logic [CNT_W-1:0] lim_a;

    // Three-way minimum of payload length, caller size and storage.
    always_comb begin
        avail    = (reply_cnt == '0) ? '0 : reply_cnt - 1'b1;
        lim_a    = (avail < buf_size) ? avail : buf_size;
        copy_cnt = !enable ? '0 : ((lim_a < DATA_CAP) ? lim_a : DATA_CAP);
    end

    // One byte lane per buffer slot, gated by the clamped count.
    for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
        assign data_out[i*8 +: 8] = (CNT_W'(i) < copy_cnt) ? payload[i*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/aux_reply_classifier.sv
// Module: top of the AUX reply classifier.
// Does: waits for completion, classifies the captured status and copies
// the ACK payload; results are registered and strobed by res_valid.
// Assumes: receiver inputs are stable on the cycle the wait ends.
module aux_reply_classifier
    import aux_cls_pkg::*;
#(
    parameter int  MAX_BYTES  = 17,
    parameter int  TMO_W      = 16,
    localparam int CNT_W      = $clog2(MAX_BYTES + 1),
    localparam int DATA_BYTES = MAX_BYTES - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [TMO_W-1:0]        tmo_cycles,
    input  logic                    done_in,
    input  logic                    hpd_lost,
    input  logic [6:0]              rx_flags,
    input  logic [CNT_W-1:0]        reply_cnt,
    input  logic [MAX_BYTES*8-1:0]  reply_bytes,
    input  logic [CNT_W-1:0]        buf_size,
    output logic                    busy,
    output logic                    res_valid,
    output logic [1:0]              outcome,
    output logic [2:0]              kind,
    output logic [CNT_W-1:0]        data_cnt,
    output logic [DATA_BYTES*8-1:0] data_out
);

    logic                    fire;
    logic                    expired;
    outcome_e                dec_outcome;
    kind_e                   dec_kind;
    logic                    dec_ack;
    logic [CNT_W-1:0]        cp_cnt;
    logic [DATA_BYTES*8-1:0] cp_data;

    aux_done_waiter #(.TMO_W(TMO_W)) i_waiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tmo_cycles (tmo_cycles),
        .done_in    (done_in),
        .hpd_lost   (hpd_lost),
        .busy       (busy),
        .fire       (fire),
        .expired    (expired)
    );

    aux_status_decoder i_decoder (
        .hpd_lost    (hpd_lost),
        .expired     (expired),
        .rx_flags    (rx_flags),
        .cnt_zero    (reply_cnt == '0),
        .status_byte (reply_bytes[7:0]),
        .outcome     (dec_outcome),
        .kind        (dec_kind),
        .is_ack      (dec_ack)
    );

    aux_payload_copier #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)) i_copier (
        .enable    (dec_ack),
        .reply_cnt (reply_cnt),
        .buf_size  (buf_size),
        .payload   (reply_bytes[MAX_BYTES*8-1:8]),
        .copy_cnt  (cp_cnt),
        .data_out  (cp_data)
    );

    // Register the result on the cycle the wait ends and strobe it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            outcome   <= OUT_OK;
            kind      <= K_NONE;
            data_cnt  <= '0;
            data_out  <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                outcome  <= dec_outcome;
                kind     <= dec_kind;
                data_cnt <= cp_cnt;
                data_out <= cp_data;
            end
        end
    end

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(outcome) && $stable(kind) && $stable(data_cnt)));

    // R3
    unplug_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(hpd_lost)) |-> (outcome == OUT_UNPLUG));

    // R4
    tmo_flag_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(hpd_lost) && ($past(rx_flags[1:0]) != 2'b00))
        |-> (outcome == OUT_TMO));

    // R9
    copy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (data_cnt <= $past(buf_size)));

    // R10
    no_copy_unless_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && kind != K_ACK) |-> (data_cnt == '0));

    // R2
    kind_none_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && outcome != OUT_OK) |-> (kind == K_NONE));

endmodule

// File: tb/test_aux_reply_classifier.sv
module test_aux_reply_classifier;

    localparam int MB = 17;
    localparam int CW = 5;
    localparam int DB = MB - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [15:0]     tmo_cycles = '0;
    logic            done_in = 1'b0;
    logic            hpd_lost = 1'b0;
    logic [6:0]      rx_flags = '0;
    logic [CW-1:0]   reply_cnt = '0;
    logic [MB*8-1:0] reply_bytes = '0;
    logic [CW-1:0]   buf_size = '0;
    logic            busy, res_valid;
    logic [1:0]      outcome;
    logic [2:0]      kind;
    logic [CW-1:0]   data_cnt;
    logic [DB*8-1:0] data_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    aux_reply_classifier i_aux_reply_classifier (
        .clk(clk), .rst_n(rst_n), .start(start), .tmo_cycles(tmo_cycles),
        .done_in(done_in), .hpd_lost(hpd_lost), .rx_flags(rx_flags),
        .reply_cnt(reply_cnt), .reply_bytes(reply_bytes), .buf_size(buf_size),
        .busy(busy), .res_valid(res_valid), .outcome(outcome), .kind(kind),
        .data_cnt(data_cnt), .data_out(data_out)
    );

    typedef struct packed {
        logic        hpd;
        logic        done;
        logic [6:0]  flags;
        logic [4:0]  cnt;
        logic [7:0]  b0;
        logic [4:0]  bsz;
        logic [1:0]  eo;
        logic [2:0]  ek;
        logic [4:0]  en;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 7'h00, 5'd5,  8'h00, 5'd16, 2'd3, 3'd7, 5'd0},  // R3
        '{1'b1, 1'b0, 7'h3F, 5'd5,  8'h00, 5'd16, 2'd3, 3'd7, 5'd0},  // R3
        '{1'b0, 1'b0, 7'h00, 5'd5,  8'h00, 5'd16, 2'd1, 3'd7, 5'd0},  // R2
        '{1'b0, 1'b1, 7'h01, 5'd5,  8'h00, 5'd16, 2'd1, 3'd7, 5'd0},  // R4
        '{1'b0, 1'b1, 7'h06, 5'd5,  8'h00, 5'd16, 2'd1, 3'd7, 5'd0},  // R4
        '{1'b0, 1'b1, 7'h04, 5'd5,  8'h00, 5'd16, 2'd2, 3'd7, 5'd0},  // R5
        '{1'b0, 1'b1, 7'h08, 5'd5,  8'h00, 5'd16, 2'd2, 3'd7, 5'd0},  // R5
        '{1'b0, 1'b1, 7'h10, 5'd5,  8'h00, 5'd16, 2'd2, 3'd7, 5'd0},  // R5
        '{1'b0, 1'b1, 7'h20, 5'd5,  8'h00, 5'd16, 2'd2, 3'd7, 5'd0},  // R5
        '{1'b0, 1'b1, 7'h40, 5'd3,  8'h00, 5'd16, 2'd0, 3'd0, 5'd2},  // R6
        '{1'b0, 1'b1, 7'h00, 5'd0,  8'h00, 5'd16, 2'd2, 3'd7, 5'd0},  // R7
        '{1'b0, 1'b1, 7'h00, 5'd1,  8'h00, 5'd16, 2'd0, 3'd0, 5'd0},  // R9
        '{1'b0, 1'b1, 7'h00, 5'd5,  8'h10, 5'd16, 2'd0, 3'd1, 5'd0},  // R8
        '{1'b0, 1'b1, 7'h00, 5'd5,  8'h20, 5'd16, 2'd0, 3'd2, 5'd0},  // R8
        '{1'b0, 1'b1, 7'h00, 5'd5,  8'h40, 5'd16, 2'd0, 3'd3, 5'd0},  // R8
        '{1'b0, 1'b1, 7'h00, 5'd5,  8'h80, 5'd16, 2'd0, 3'd4, 5'd0},  // R8
        '{1'b0, 1'b1, 7'h00, 5'd5,  8'h30, 5'd16, 2'd0, 3'd5, 5'd0},  // R8
        '{1'b0, 1'b1, 7'h00, 5'd4,  8'h0F, 5'd16, 2'd0, 3'd0, 5'd3},  // R8
        '{1'b0, 1'b1, 7'h00, 5'd17, 8'h00, 5'd16, 2'd0, 3'd0, 5'd16}, // R9
        '{1'b0, 1'b1, 7'h00, 5'd10, 8'h00, 5'd4,  2'd0, 3'd0, 5'd4},  // R9
        '{1'b0, 1'b1, 7'h00, 5'd31, 8'h00, 5'd31, 2'd0, 3'd0, 5'd16}  // R9
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Launch one transaction; done rises before sampling edge done_at (0/1 = at once).
    task automatic run(input string req, input logic hpd, input int done_at,
                       input logic [6:0] flags, input logic [4:0] cnt,
                       input logic [7:0] b0, input logic [4:0] bsz,
                       input int tmo, input logic [1:0] eo, input logic [2:0] ek,
                       input logic [4:0] en, input int lat);
        int k;
        logic [DB*8-1:0] exp_d;
        @(negedge clk);
        hpd_lost   = hpd;
        rx_flags   = flags;
        reply_cnt  = cnt;
        buf_size   = bsz;
        tmo_cycles = 16'(tmo);
        reply_bytes[7:0] = b0;
        for (int j = 1; j < MB; j++) reply_bytes[j*8 +: 8] = 8'(8'h10 + j);
        done_in = 1'b0;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        done_in = (done_at <= 1);
        k = 0;
        while (k < 64) begin
            @(negedge clk);
            k++;
            if (res_valid) break;
            done_in = (k + 1 >= done_at);
        end
        check(req, "latency", 32'(k), 32'(lat));
        check(req, "outcome", 32'(outcome), 32'(eo));
        check(req, "kind", 32'(kind), 32'(ek));
        check(req, "data_cnt", 32'(data_cnt), 32'(en));
        for (int i = 0; i < DB; i++) exp_d[i*8 +: 8] = (i < int'(en)) ? 8'(8'h11 + i) : 8'h00;
        check(req, "data_out", 32'(data_out != exp_d), 32'd0);
        done_in  = 1'b0;
        hpd_lost = 1'b0;
        rx_flags = '0;
        @(negedge clk);
        // R11 strobe drops and result holds
        check("R11", "pulse", 32'(res_valid), 32'd0);
        check("R11", "hold", 32'({outcome, kind}), 32'({eo, ek}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "res_valid", 32'(res_valid), 32'd0);
        check("R1", "outcome", 32'(outcome), 32'd0);
        check("R1", "kind", 32'(kind), 32'd7);
        check("R1", "data", 32'({data_cnt, |data_out}), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run($sformatf("vec%0d", v), VECS[v].hpd, VECS[v].done ? 0 : 999,
                VECS[v].flags, VECS[v].cnt, VECS[v].b0, VECS[v].bsz, 3,
                VECS[v].eo, VECS[v].ek, VECS[v].en,
                (VECS[v].hpd || VECS[v].done) ? 1 : 4);
        end

        // R2 longer window, done never seen
        run("R2", 1'b0, 999, 7'h00, 5'd5, 8'h00, 5'd16, 5, 2'd1, 3'd7, 5'd0, 6);
        // R2 zero window times out on the first sample
        run("R2", 1'b0, 999, 7'h00, 5'd5, 8'h00, 5'd16, 0, 2'd1, 3'd7, 5'd0, 1);
        // R2 done on the last allowed sample still succeeds
        run("R2", 1'b0, 6, 7'h00, 5'd3, 8'h00, 5'd16, 5, 2'd0, 3'd0, 5'd2, 6);
        // R10 non-ACK after an ACK clears the buffer
        run("R10", 1'b0, 0, 7'h00, 5'd9, 8'h20, 5'd16, 2, 2'd0, 3'd2, 5'd0, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule